// File: doc/BRIEF.md
# Escaped Frame Transmitter with FCS-16

This block turns a command payload, presented one byte at a time on a valid/ready stream with an end-of-payload marker, into a delimited and byte-stuffed frame for an asynchronous serial link. It writes a flag byte, then the payload, then a 16-bit frame check sequence, then a closing flag. Any flag or escape value that turns up in the payload or in the check sequence is replaced by a two-byte escape pair.

The check sequence is the PPP-style FCS-16. It is computed over the unescaped payload bytes only, at a rate of one byte per accepted input, with a loop over the eight bits of the byte and no lookup table. The upstream source supplies the command code and its little-endian fields. This block does not look inside them.

Back-pressure rules: an output byte is transferred on any rising edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, `tx_byte` holds its value. A payload byte is taken on a rising edge where `pl_valid` and `pl_ready` are both high. While the payload itself is flowing, `pl_ready` follows `tx_ready`. The source must hold `pl_valid`, `pl_byte` and `pl_end` steady until the byte is taken. `pl_ready` is low in all other phases: the flags, the second byte of an escape pair, and the check bytes.

Top module: `frame_stuff_tx`

## Requirements
- R1: The first byte of every frame is the flag 0x7e. It is sent before any payload byte is accepted.
- R2: The last byte of every frame is the flag 0x7e. No byte between the two flags equals 0x7e.
- R3: A payload byte 0x7e is sent as the pair 0x7d, 0x5e.
- R4: A payload byte 0x7d is sent as the pair 0x7d, 0x5d. All other values pass through unchanged, including 0x7c and 0x7f.
- R5: The two bytes before the closing flag are the FCS-16 of the unescaped payload, sent low byte first. The FCS uses the reflected polynomial 0x8408, starts at 0xFFFF and is complemented at the end. For the ASCII payload "123456789" the two bytes are 0x6e, 0x90.
- R6: A check byte equal to 0x7e or 0x7d is escaped by the same rule as a payload byte.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_byte` does not change.
- R8: `pl_ready` is low while a flag, an escape second byte or a check byte is being sent. After a reserved payload byte is accepted, `pl_ready` is low on the next cycle.
- R9: While reset is asserted, `tx_valid` and `pl_ready` are low.
- R10: Frames can follow one another with no gap, and the check sequence restarts for each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pl_valid | input | 1 | Payload byte available |
| pl_ready | output | 1 | Payload byte taken on this edge if `pl_valid` is high |
| pl_byte | input | 8 | Payload byte |
| pl_end | input | 1 | Marks the last byte of the payload |
| tx_valid | output | 1 | Output byte available |
| tx_ready | input | 1 | Link accepts the output byte |
| tx_byte | output | 8 | Output byte of the frame |

## Verification
Each payload is tried with several patterns:
- Command-shaped payloads whose check bytes are known in advance. These show the FCS polynomial, its start value, the final complement and the byte order. A payload that differs from another in one address byte (0x7c, 0x7d, 0x7e or 0x7f) tells escaping apart from pass-through.
- A one-byte payload of 0x7e. This shows an escape on the last byte, followed by the check bytes.
- A two-byte payload, found by search, whose check sequence contains a reserved value. This shows that the check bytes are escaped.

The patterns run once with the output always ready and once under a pseudo-random stall pattern, which separates data errors from handshake errors. A stall held on the opening flag shows that the output is held and that input is blocked.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int FCS_W = 16;
  localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7e;
  localparam logic [BYTE_W-1:0] ESC_BYTE = 8'h7d;
  localparam logic [BYTE_W-1:0] ESC_XOR = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_BODY, ST_ESC2, ST_FCS_LO, ST_FCS_HI, ST_CLOSE
  } tx_state_e;

  function automatic logic is_reserved(input logic [BYTE_W-1:0] b);
    return (b == FLAG_BYTE) || (b == ESC_BYTE);
  endfunction

  // Reflected CRC step over one byte, one bit per loop pass.
  function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] c,
                                                input logic [BYTE_W-1:0] d,
                                                input logic [FCS_W-1:0] poly);
    logic [FCS_W-1:0] r;
    r = c ^ {{(FCS_W-BYTE_W){1'b0}}, d};
    for (int k = 0; k < BYTE_W; k++)
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/fcs16_acc.sv
module fcs16_acc
  import frame_tx_pkg::*;
#(
  parameter logic [FCS_W-1:0] POLY = 16'h8408,
  parameter logic [FCS_W-1:0] SEED = 16'hffff
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              upd,
  input  logic [BYTE_W-1:0] din,
  output logic [FCS_W-1:0]  fcs_out
);
  logic [FCS_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= SEED;
    else if (restart) acc_q <= SEED;
    else if (upd)     acc_q <= fcs_step(acc_q, din, POLY);
  end

  // The final complement is applied here.
  assign fcs_out = ~acc_q;
endmodule

// File: rtl/frame_tx_fsm.sv
module frame_tx_fsm
  import frame_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [BYTE_W-1:0] pl_byte,
  input  logic              pl_end,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic [FCS_W-1:0]  fcs_val,
  output logic              fcs_restart,
  output logic              fcs_upd
);
  tx_state_e state_q, state_d, ret_q, ret_d;
  logic [BYTE_W-1:0] esc_q, esc_d;
  logic [BYTE_W-1:0] chk_byte;
  tx_state_e chk_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_IDLE;
      esc_q   <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      esc_q   <= esc_d;
    end
  end

  assign chk_byte = (state_q == ST_FCS_HI) ? fcs_val[FCS_W-1:BYTE_W]
                                           : fcs_val[BYTE_W-1:0];
  assign chk_next = (state_q == ST_FCS_HI) ? ST_CLOSE : ST_FCS_HI;

  always_comb begin
    state_d     = state_q;
    ret_d       = ret_q;
    esc_d       = esc_q;
    tx_valid    = 1'b0;
    tx_byte     = FLAG_BYTE;
    pl_ready    = 1'b0;
    fcs_upd     = 1'b0;
    fcs_restart = (state_q == ST_IDLE);
    unique case (state_q)
      ST_IDLE: if (pl_valid) state_d = ST_OPEN;
      ST_OPEN, ST_CLOSE: begin
        tx_valid = 1'b1;
        if (tx_ready) state_d = (state_q == ST_OPEN) ? ST_BODY : ST_IDLE;
      end
      ST_BODY: begin
        tx_valid = pl_valid;
        pl_ready = tx_ready;
        tx_byte  = is_reserved(pl_byte) ? ESC_BYTE : pl_byte;
        if (pl_valid && tx_ready) begin
          fcs_upd = 1'b1;
          if (is_reserved(pl_byte)) begin
            state_d = ST_ESC2;
            esc_d   = pl_byte ^ ESC_XOR;
            ret_d   = pl_end ? ST_FCS_LO : ST_BODY;
          end else if (pl_end) begin
            state_d = ST_FCS_LO;
          end
        end
      end
      ST_ESC2: begin
        tx_valid = 1'b1;
        tx_byte  = esc_q;
        if (tx_ready) state_d = ret_q;
      end
      ST_FCS_LO, ST_FCS_HI: begin
        tx_valid = 1'b1;
        tx_byte  = is_reserved(chk_byte) ? ESC_BYTE : chk_byte;
        if (tx_ready) begin
          if (is_reserved(chk_byte)) begin
            state_d = ST_ESC2;
            esc_d   = chk_byte ^ ESC_XOR;
            ret_d   = chk_next;
          end else begin
            state_d = chk_next;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/frame_stuff_tx.sv
module frame_stuff_tx
  import frame_tx_pkg::*;
#(
  parameter logic [FCS_W-1:0] FCS_POLY = 16'h8408,
  parameter logic [FCS_W-1:0] FCS_SEED = 16'hffff
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [BYTE_W-1:0] pl_byte,
  input  logic              pl_end,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_byte
);
  logic [FCS_W-1:0] fcs_val;
  logic fcs_restart, fcs_upd;

  fcs16_acc #(.POLY(FCS_POLY), .SEED(FCS_SEED)) fcs_i (
    .clk(clk), .rst_n(rst_n), .restart(fcs_restart), .upd(fcs_upd),
    .din(pl_byte), .fcs_out(fcs_val)
  );

  frame_tx_fsm seq_i (
    .clk(clk), .rst_n(rst_n),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_byte(pl_byte), .pl_end(pl_end),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
    .fcs_val(fcs_val), .fcs_restart(fcs_restart), .fcs_upd(fcs_upd)
  );
endmodule

// File: rtl/frame_stuff_tx_chk.sv
module frame_stuff_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pl_valid,
  input logic       pl_ready,
  input logic [7:0] pl_byte,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_byte
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R9: assert (!tx_valid && !pl_ready)
        else $error("R9: output or ready active in reset");
    end
  end

  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  // Covers R3 and R4: an escape byte is always followed by 0x5e or 0x5d.
  assert_escape_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_byte == 8'h7d) |=>
      (tx_valid && (tx_byte == 8'h5e || tx_byte == 8'h5d)));

  assert_block_after_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && pl_ready && (pl_byte == 8'h7e || pl_byte == 8'h7d)) |=> !pl_ready);

  assert_no_inner_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && pl_ready) |-> (tx_valid && tx_byte != 8'h7e));
endmodule

bind frame_stuff_tx frame_stuff_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pl_valid(pl_valid), .pl_ready(pl_ready),
  .pl_byte(pl_byte), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte)
);

// File: tb/frame_stuff_tx_tb.sv
module frame_stuff_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pl_valid = 1'b0, pl_end = 1'b0, tx_ready = 1'b1;
  logic [7:0] pl_byte = 8'h00;
  logic pl_ready, tx_valid;
  logic [7:0] tx_byte;

  int checks = 0, fails = 0;
  bit rand_ready = 0, stall = 0;
  logic [15:0] lfsr = 16'hace1;
  logic [7:0] cap [128];
  int cap_n = 0;

  always #4 clk = ~clk;

  frame_stuff_tx dut_i (
    .clk(clk), .rst_n(rst_n), .pl_valid(pl_valid), .pl_ready(pl_ready),
    .pl_byte(pl_byte), .pl_end(pl_end), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_byte(tx_byte)
  );

  // Payload vectors: byte i sits at bits [8*i +: 8]. A known check value of 0 means the model value is used.
  localparam int NV = 7;
  localparam logic [127:0] V_DATA [NV] = '{
    128'h393837363534333231,
    128'h000000020000eeee0002020d,
    128'h000000020000ee7e0002020d,
    128'h000000020000ee7d0002020d,
    128'h000000020000ee7c0002020d,
    128'h000000020000ee7f0002020d,
    128'h7e };
  localparam int V_LEN [NV] = '{9, 12, 12, 12, 12, 12, 1};
  localparam logic [15:0] V_FCS [NV] = '{16'h906e, 16'hac5c, 16'h3cc6,
                                          16'hb616, 16'h37a9, 16'hbd79, 16'h0000};

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = stall ? 1'b0 : (rand_ready ? lfsr[0] | lfsr[3] : 1'b1);
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && tx_valid && tx_ready && cap_n < 128) begin
      cap[cap_n] = tx_byte;
      cap_n = cap_n + 1;
    end
  end

  function automatic logic [15:0] model_fcs(input logic [127:0] d, input int n);
    logic [15:0] c = 16'hffff;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, d[8*i +: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [127:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pl_valid = 1'b1; pl_byte = d[8*i +: 8]; pl_end = (i == n - 1);
      forever begin
        #1;
        if (pl_ready) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    pl_valid = 1'b0; pl_end = 1'b0;
  endtask

  task automatic run_frame(input logic [127:0] d, input int n, input logic [15:0] known, input string tag);
    logic [7:0] ex [128];
    int en = 0, wait_cyc = 0;
    logic [15:0] f = (known != 0) ? known : model_fcs(d, n);
    logic [7:0] b;
    ex[en++] = 8'h7e;
    for (int i = 0; i < n + 2; i++) begin
      b = (i < n) ? d[8*i +: 8] : (i == n ? f[7:0] : f[15:8]);
      if (b == 8'h7e || b == 8'h7d) begin ex[en++] = 8'h7d; ex[en++] = b ^ 8'h20; end
      else ex[en++] = b;
    end
    ex[en++] = 8'h7e;
    cap_n = 0;
    drive(d, n);
    while (cap_n < en && wait_cyc < 400) begin @(negedge clk); wait_cyc++; end
    @(negedge clk);
    check(cap_n == en, {tag, " R2 frame length"}, cap_n, en);
    for (int i = 0; i < en; i++)
      check(cap[i] == ex[i], (i == 0) ? {tag, " R1 open"} : (i == en - 1) ? {tag, " R2 close"}
            : {tag, " R5 body/fcs"}, cap[i], ex[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!tx_valid, "R9 tx_valid in reset", tx_valid, 0);
    check(!pl_ready, "R9 pl_ready in reset", pl_ready, 0);
    @(negedge clk); rst_n = 1'b1;
    // Table pass: ready always high, then under random stalls; frames back to back (R10).
    for (int pass = 0; pass < 2; pass++) begin
      rand_ready = (pass == 1);
      for (int v = 0; v < NV; v++)
        run_frame(V_DATA[v], V_LEN[v], V_FCS[v],
                  v == 2 || v == 6 ? "R3" : v == 3 ? "R4" : v >= 4 ? "R4 pass" : "R10 R5");
    end
    rand_ready = 0;
    // R6: two-byte payload whose check sequence holds a reserved value.
    for (int s = 0; s < 65536; s++) begin
      logic [15:0] f = model_fcs(128'(s), 2);
      if (f[7:0] == 8'h7e || f[7:0] == 8'h7d || f[15:8] == 8'h7e || f[15:8] == 8'h7d) begin
        run_frame(128'(s), 2, 16'h0000, "R6");
        break;
      end
    end
    // R7 and R8: stall on the opening flag.
    stall = 1;
    cap_n = 0;
    fork
      drive(128'h41, 1);
      begin
        repeat (5) @(negedge clk);
        #1;
        check(tx_valid && tx_byte == 8'h7e, "R7 held flag", tx_byte, 8'h7e);
        check(!pl_ready, "R8 ready low on flag", pl_ready, 0);
        stall = 0;
      end
    join
    repeat (10) @(negedge clk);
    check(cap_n == 5 && cap[0] == 8'h7e && cap[1] == 8'h41, "R7 stalled frame", cap_n, 5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule